// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words. It moves data between two clock domains that need not share any relationship; the two clocks may also be the same net. Each side qualifies its transfers with a pair of enables, and both must be high for a transfer to happen. The read side presents each word through an output register, and an output enable can release the bus.

Four flags report the fill level. Full and almost-full are computed with the write clock. Empty and almost-empty are computed with the read clock. The two almost thresholds start at 7 words and can be reprogrammed over the data bus. While the load input is high, each write-enabled cycle stores one byte into a threshold register, and a small sequencer steps through the byte slots in turn. The pointers cross between domains in Gray code through two-stage synchronizers. A flag can therefore lag a change made in the opposite domain by a few cycles of its own clock. Because it lags, a flag can only report the FIFO as fuller (full side) or emptier (empty side) than it really is.

Top module: `dualclk_fifo9`

## Requirements
- R1: While reset is low, and after it is released, the FIFO is empty: emptyFlag=1, almostEmptyFlag=1, fullFlag=0, almostFullFlag=0. The output register holds 0, and both thresholds return to 7.
- R2: On a rising wrClk edge where wrEnA and wrEnB are both 1 and cfgLoad is 0, dataIn is stored. If only one enable is high, nothing is stored. Words come out in the order they were written.
- R3: On a rising rdClk edge where rdEnA and rdEnB are both 1 and the FIFO is not empty, the oldest word is loaded into the output register. In every other cycle the output register holds its value.
- R4: fullFlag is 1 exactly when DEPTH words are stored, and emptyFlag is 1 exactly when none are. Each flag settles within three cycles of its own clock after a change made in the other domain.
- R5: A write attempted while fullFlag is 1 is ignored. The stored data and the pointers stay unchanged.
- R6: A read attempted while emptyFlag is 1 is ignored, and the output register keeps its last word.
- R7: almostEmptyFlag is 1 when the occupancy is less than or equal to the empty threshold. almostFullFlag is 1 when the occupancy plus the full threshold is at least DEPTH. Both thresholds default to 7.
- R8: While cfgLoad is 1, each wrClk cycle with both write enables high copies dataIn[7:0] into the next byte slot and stores nothing in the FIFO. The slots are filled in this order: empty-threshold bits 7:0, empty-threshold bits 15:8, full-threshold bits 7:0, full-threshold bits 15:8. After the fourth slot the order wraps to the first. The order restarts at the first slot whenever cfgLoad is 0.
- R9: While outEn is 0, dataOut is high impedance. While outEn is 1, dataOut drives the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wrClk | input | 1 | Write clock |
| wrEnA | input | 1 | First write enable |
| wrEnB | input | 1 | Second write enable |
| cfgLoad | input | 1 | Selects threshold loading instead of data writes |
| dataIn | input | 9 | Write data, or threshold byte in bits 7:0 |
| rdClk | input | 1 | Read clock |
| rdEnA | input | 1 | First read enable |
| rdEnB | input | 1 | Second read enable |
| outEn | input | 1 | Drives dataOut when 1, high impedance when 0 |
| dataOut | output | 9 | Registered read data |
| fullFlag | output | 1 | FIFO holds DEPTH words (write domain) |
| almostFullFlag | output | 1 | Occupancy at or above DEPTH minus the full threshold (write domain) |
| emptyFlag | output | 1 | FIFO holds no words (read domain) |
| almostEmptyFlag | output | 1 | Occupancy at or below the empty threshold (read domain) |

## Verification
A push and a pop can fall in the same time window. The write pointer then advances while the read pointer also advances, and each domain sees the other pointer only through its synchronizer. The bench provokes this by filling the FIFO with three words, then starting a four-word write burst and a two-word read burst in parallel on the two unrelated clocks. The outcome is judged by checking that the words drained afterwards keep their write order, and that the settled flags show an occupancy of five.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;
  localparam int DATA_W = 9;
  localparam int PART_W = 8;
  localparam int OFF_W  = 2 * PART_W;
  localparam logic [OFF_W-1:0] OFF_DEFAULT = OFF_W'(7);

  typedef enum logic [1:0] {
    SEL_EMPTY_LO = 2'd0,
    SEL_EMPTY_HI = 2'd1,
    SEL_FULL_LO  = 2'd2,
    SEL_FULL_HI  = 2'd3
  } offSel_e;

  typedef struct packed {
    logic    push;
    logic    pop;
    logic    cfgWr;
    offSel_e cfgSel;
  } ctlStrobe_t;
endpackage

// File: rtl/fifo9_sync.sv
module fifo9_sync #(
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/fifo9_ctrl.sv
module fifo9_ctrl
  import fifo9_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEnA,
  input  logic              wrEnB,
  input  logic              cfgLoad,
  input  logic              rdEnA,
  input  logic              rdEnB,
  input  logic [OFF_W-1:0]  emptyOff,
  input  logic [OFF_W-1:0]  fullOff,
  output ctlStrobe_t        strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              fullFlag,
  output logic              almostFullFlag,
  output logic              emptyFlag,
  output logic              almostEmptyFlag
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int CMP_W = OFF_W + 1;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
  localparam logic [CMP_W-1:0] DEPTH_C = CMP_W'(DEPTH);

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fromGray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic             wrReq, pushOk, cfgWr;
  offSel_e          cfgSel;
  logic [PTR_W-1:0] wPtrBin, wPtrGray, rPtrGraySync, wCount, wPtrNext;
  logic [PTR_W-1:0] rPtrBin, rPtrGray;

  assign wrReq    = wrEnA & wrEnB;
  assign pushOk   = wrReq & ~cfgLoad & ~fullFlag;
  assign cfgWr    = wrReq & cfgLoad;
  assign wPtrNext = wPtrBin + PTR_W'(1);

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wPtrBin  <= '0;
      wPtrGray <= '0;
    end else if (pushOk) begin
      wPtrBin  <= wPtrNext;
      wPtrGray <= toGray(wPtrNext);
    end
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN)        cfgSel <= SEL_EMPTY_LO;
    else if (!cfgLoad) cfgSel <= SEL_EMPTY_LO;
    else if (cfgWr)   cfgSel <= offSel_e'(2'(cfgSel + 2'd1));
  end

  fifo9_sync #(.WIDTH(PTR_W)) uRdPtrSync (
    .clk (wrClk),
    .rstN(rstN),
    .d   (rPtrGray),
    .q   (rPtrGraySync)
  );

  assign wCount         = wPtrBin - fromGray(rPtrGraySync);
  assign fullFlag       = (wCount == DEPTH_P);
  assign almostFullFlag = ((CMP_W'(wCount) + CMP_W'(fullOff)) >= DEPTH_C);

  // ---------------- read domain ----------------
  logic             rdReq, popOk;
  logic [PTR_W-1:0] wPtrGraySync, rCount, rPtrNext;
  logic [OFF_W-1:0] emptyOffRd;

  assign rdReq    = rdEnA & rdEnB;
  assign popOk    = rdReq & ~emptyFlag;
  assign rPtrNext = rPtrBin + PTR_W'(1);

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rPtrBin  <= '0;
      rPtrGray <= '0;
    end else if (popOk) begin
      rPtrBin  <= rPtrNext;
      rPtrGray <= toGray(rPtrNext);
    end
  end

  fifo9_sync #(.WIDTH(PTR_W)) uWrPtrSync (
    .clk (rdClk),
    .rstN(rstN),
    .d   (wPtrGray),
    .q   (wPtrGraySync)
  );

  fifo9_sync #(.WIDTH(OFF_W), .RST_VAL(OFF_DEFAULT)) uEmptyOffSync (
    .clk (rdClk),
    .rstN(rstN),
    .d   (emptyOff),
    .q   (emptyOffRd)
  );

  assign rCount          = fromGray(wPtrGraySync) - rPtrBin;
  assign emptyFlag       = (rCount == '0);
  assign almostEmptyFlag = (CMP_W'(rCount) <= CMP_W'(emptyOffRd));

  // ---------------- strobes to the datapath ----------------
  assign strobe.push   = pushOk;
  assign strobe.pop    = popOk;
  assign strobe.cfgWr  = cfgWr;
  assign strobe.cfgSel = cfgSel;
  assign wrAddr        = wPtrBin[ADDR_W-1:0];
  assign rdAddr        = rPtrBin[ADDR_W-1:0];

  // R5
  no_overflow_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrReq && !cfgLoad && fullFlag) |=> $stable(wPtrBin));

  // R6
  no_underflow_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdReq && emptyFlag) |=> $stable(rPtrBin));

  // R4
  full_in_af_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    fullFlag |-> almostFullFlag);

  // R4
  empty_in_ae_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    emptyFlag |-> almostEmptyFlag);

  // R2
  gray_step_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    $onehot0(wPtrGray ^ $past(wPtrGray)));
endmodule

// File: rtl/fifo9_datapath.sv
module fifo9_datapath
  import fifo9_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] qWord,
  output logic [OFF_W-1:0]  emptyOff,
  output logic [OFF_W-1:0]  fullOff
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.push) mem[wrAddr] <= dataIn;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      emptyOff <= OFF_DEFAULT;
      fullOff  <= OFF_DEFAULT;
    end else if (strobe.cfgWr) begin
      unique case (strobe.cfgSel)
        SEL_EMPTY_LO: emptyOff[PART_W-1:0]     <= dataIn[PART_W-1:0];
        SEL_EMPTY_HI: emptyOff[OFF_W-1:PART_W] <= dataIn[PART_W-1:0];
        SEL_FULL_LO:  fullOff[PART_W-1:0]      <= dataIn[PART_W-1:0];
        SEL_FULL_HI:  fullOff[OFF_W-1:PART_W]  <= dataIn[PART_W-1:0];
      endcase
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)           qWord <= '0;
    else if (strobe.pop) qWord <= mem[rdAddr];
  end

  // R8
  load_no_push_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    !(strobe.push && strobe.cfgWr));

  // R3
  hold_q_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    !strobe.pop |=> $stable(qWord));
endmodule

// File: rtl/dualclk_fifo9.sv
module dualclk_fifo9
  import fifo9_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic              rstN,
  input  logic              wrClk,
  input  logic              wrEnA,
  input  logic              wrEnB,
  input  logic              cfgLoad,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              rdClk,
  input  logic              rdEnA,
  input  logic              rdEnB,
  input  logic              outEn,
  output logic [DATA_W-1:0] dataOut,
  output logic              fullFlag,
  output logic              almostFullFlag,
  output logic              emptyFlag,
  output logic              almostEmptyFlag
);
  localparam int ADDR_W = $clog2(DEPTH);

  ctlStrobe_t        strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [OFF_W-1:0]  emptyOff, fullOff;
  logic [DATA_W-1:0] qWord;

  fifo9_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) uCtrl (
    .wrClk          (wrClk),
    .rdClk          (rdClk),
    .rstN           (rstN),
    .wrEnA          (wrEnA),
    .wrEnB          (wrEnB),
    .cfgLoad        (cfgLoad),
    .rdEnA          (rdEnA),
    .rdEnB          (rdEnB),
    .emptyOff       (emptyOff),
    .fullOff        (fullOff),
    .strobe         (strobe),
    .wrAddr         (wrAddr),
    .rdAddr         (rdAddr),
    .fullFlag       (fullFlag),
    .almostFullFlag (almostFullFlag),
    .emptyFlag      (emptyFlag),
    .almostEmptyFlag(almostEmptyFlag)
  );

  fifo9_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) uData (
    .wrClk   (wrClk),
    .rdClk   (rdClk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddr),
    .dataIn  (dataIn),
    .qWord   (qWord),
    .emptyOff(emptyOff),
    .fullOff (fullOff)
  );

  assign dataOut = outEn ? qWord : 'z;
endmodule

// File: tb/sim_dualclk_fifo9.sv
module sim_dualclk_fifo9;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int DEPTH      = 32;
  localparam int WATCHDOG   = 150000;
  localparam int VEC_N      = 9;
  // columns: writes, reads, empty, almostEmpty, almostFull, full
  localparam int VEC [VEC_N][6] = '{
    '{5, 0, 0, 1, 0, 0},
    '{3, 0, 0, 0, 0, 0},
    '{0, 1, 0, 1, 0, 0},
    '{20, 0, 0, 0, 1, 0},
    '{5, 0, 0, 0, 1, 1},
    '{3, 0, 0, 0, 1, 1},
    '{0, 8, 0, 0, 0, 0},
    '{0, 24, 1, 1, 0, 0},
    '{0, 3, 1, 1, 0, 0}
  };

  logic rstN = 0, wrClk = 0, rdClk = 0;
  logic wrEnA = 0, wrEnB = 0, cfgLoad = 0, rdEnA = 0, rdEnB = 0, outEn = 1;
  logic [8:0] dataIn = '0;
  tri1  [8:0] dataOut;
  logic fullFlag, almostFullFlag, emptyFlag, almostEmptyFlag;

  int errors = 0, checks = 0, nextVal = 1;
  logic [8:0] model[$];
  logic [8:0] lastRead = '0;

  always #(CLK_PERIOD / 2) wrClk = ~wrClk;
  always #(RD_PERIOD / 2) rdClk = ~rdClk;

  dualclk_fifo9 #(.DEPTH(DEPTH)) u0 (
    .rstN(rstN), .wrClk(wrClk), .wrEnA(wrEnA), .wrEnB(wrEnB), .cfgLoad(cfgLoad),
    .dataIn(dataIn), .rdClk(rdClk), .rdEnA(rdEnA), .rdEnB(rdEnB), .outEn(outEn),
    .dataOut(dataOut), .fullFlag(fullFlag), .almostFullFlag(almostFullFlag),
    .emptyFlag(emptyFlag), .almostEmptyFlag(almostEmptyFlag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge rdClk);
    repeat (6) @(negedge wrClk);
  endtask

  task automatic checkFlags(input int e, input int ae, input int af, input int f, input string req);
    check({req, " empty"}, int'(emptyFlag), e);
    check({req, " almostEmpty"}, int'(almostEmptyFlag), ae);
    check({req, " almostFull"}, int'(almostFullFlag), af);
    check({req, " full"}, int'(fullFlag), f);
  endtask

  task automatic doWrites(input int n);
    if (n == 0) return;
    for (int i = 0; i < n; i++) begin
      @(negedge wrClk);
      wrEnA = 1; wrEnB = 1; dataIn = 9'(nextVal);
      if (model.size() < DEPTH) model.push_back(9'(nextVal));
      nextVal++;
    end
    @(negedge wrClk);
    wrEnA = 0; wrEnB = 0;
  endtask

  task automatic doReads(input int n, input string req);
    logic [8:0] exp;
    if (n == 0) return;
    @(negedge rdClk);
    rdEnA = 1; rdEnB = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge rdClk);
      exp = (model.size() > 0) ? model.pop_front() : lastRead;
      lastRead = exp;
      check({req, " read data"}, int'(dataOut), int'(exp));
    end
    rdEnA = 0; rdEnB = 0;
  endtask

  task automatic doLoad(input logic [7:0] b);
    @(negedge wrClk);
    cfgLoad = 1; wrEnA = 1; wrEnB = 1; dataIn = {1'b0, b};
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge wrClk);
    errors++; checks++;
    $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge wrClk);
    // R1: reset state
    checkFlags(1, 1, 0, 0, "R1 in reset");
    rstN = 1;
    repeat (3) @(negedge rdClk);
    checkFlags(1, 1, 0, 0, "R1 after reset");
    check("R1 output register", int'(dataOut), 0);

    // R9: output enable
    outEn = 0; #1;
    check("R9 released bus", int'(dataOut), 9'h1FF);
    outEn = 1; #1;
    check("R9 driven bus", int'(dataOut), 0);

    // R2: a single write enable stores nothing
    @(negedge wrClk); wrEnA = 1; wrEnB = 0; dataIn = 9'h055;
    @(negedge wrClk); wrEnA = 0; wrEnB = 1;
    @(negedge wrClk); wrEnB = 0;
    settle();
    check("R2 single enable empty", int'(emptyFlag), 1);

    // vector table: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < VEC_N; v++) begin
      doWrites(VEC[v][0]);
      doReads(VEC[v][1], "R2 R3 R5 R6");
      settle();
      checkFlags(VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], $sformatf("R4 R7 vec%0d", v));
    end

    // R3: a single read enable does not read
    doWrites(1);
    settle();
    @(negedge rdClk); rdEnA = 1;
    repeat (3) @(negedge rdClk);
    rdEnA = 0;
    check("R3 single read enable holds", int'(dataOut), int'(lastRead));
    settle();
    check("R3 single read enable keeps word", int'(emptyFlag), 0);
    doReads(1, "R3");

    // concurrent push and pop
    doWrites(3);
    settle();
    fork
      doWrites(4);
      doReads(2, "R2 concurrent");
    join
    settle();
    checkFlags(0, 1, 0, 0, "R4 R7 concurrent occ5");
    doReads(5, "R2 concurrent drain");
    settle();
    check("R4 drained", int'(emptyFlag), 1);

    // R8: threshold loading, with wrap to the first slot
    doLoad(8'd3); doLoad(8'd0); doLoad(8'd2); doLoad(8'd0); doLoad(8'd5);
    @(negedge wrClk); cfgLoad = 0; wrEnA = 0; wrEnB = 0;
    settle();
    check("R8 load stores no data", int'(emptyFlag), 1);
    doWrites(5); settle();
    check("R8 empty threshold 5 at occ5", int'(almostEmptyFlag), 1);
    doWrites(1); settle();
    check("R8 empty threshold 5 at occ6", int'(almostEmptyFlag), 0);
    doWrites(23); settle();
    check("R8 full threshold 2 at occ29", int'(almostFullFlag), 0);
    doWrites(1); settle();
    check("R8 full threshold 2 at occ30", int'(almostFullFlag), 1);

    // R1: reset restores thresholds of 7
    @(negedge wrClk); rstN = 0;
    @(negedge wrClk); rstN = 1;
    model.delete(); lastRead = '0;
    settle();
    checkFlags(1, 1, 0, 0, "R1 re-reset");
    doWrites(7); settle();
    check("R1 default empty threshold occ7", int'(almostEmptyFlag), 1);
    doWrites(1); settle();
    check("R1 default empty threshold occ8", int'(almostEmptyFlag), 0);
    doWrites(16); settle();
    check("R1 default full threshold occ24", int'(almostFullFlag), 0);
    doWrites(1); settle();
    check("R1 default full threshold occ25", int'(almostFullFlag), 1);

    summary();
    $finish;
  end
endmodule